// File: doc/BRIEF.md
# Chip-Select Decoder with Wait-State Acknowledge

This unit holds eight programmable chip-select channels. Each channel carries a base, an address mask over the upper sixteen address bits, an access-type mask, a valid bit and a control word. When a bus cycle starts, the unit compares the address and the access type with every channel. It drives the active-low select of the winning channel. After the number of wait states programmed for that channel, it raises an internal transfer acknowledge. The auto-acknowledge can be turned off for a channel. An external acknowledge can end any cycle early.

Channel 0 works as a global boot select. While its valid bit is clear, it answers every address and every access type, so that a boot memory can be reached before software programs the unit. If a cycle matches no channel, no select is driven and no internal acknowledge is produced, and the cycle runs as an ordinary external bus cycle.

Top module: `csel_unit`

## Requirements
- R1: Registers are selected by `reg_addr` = {channel[2:0], field[1:0]}. Field 0 is the base, field 1 is the address mask, field 2 is the control word and field 3 is the attribute word. `reg_rdata` returns the selected register at once. In the control word, bits 15, 14 and 9 read 0 and ignore writes. In the attribute word, only bits 5:0 exist and the rest read 0.
- R2: After reset every valid bit is 0 and channel 0 has mask 0xFFFF and control 0x3D00 (15 wait states, auto-acknowledge on). Every other channel register of channels 1 to 7 reads 0. All selects are high and `int_ack` is low.
- R3: A channel's address range matches when ((`bus_addr[31:16]` XOR base) AND NOT mask) is zero.
- R4: Attribute bit 0 is the valid bit. Bits 1 to 5 block the access types CPU-space/interrupt-acknowledge (`acc_type` 0), supervisor code (1), supervisor data (2), user code (3) and user data (4). A blocked access type drives no select and no internal acknowledge.
- R5: Channels 1 to 7 never select while their valid bit is 0.
- R6: While its valid bit is 0, channel 0 selects on every address and access type. Once the bit is 1, it decodes like the other channels.
- R7: When several channels match, the lowest-numbered channel wins.
- R8: Control bits 13:10 hold N, from 0 to 15. With auto-acknowledge on (control bit 8), `int_ack` rises in the (N+1)th cycle of the select, and the select lasts N+1 cycles.
- R9: With control bit 8 at 0, `int_ack` never rises, and the cycle ends only on `ext_ack`.
- R10: `ext_ack` during an active select ends the cycle in that same cycle, and it suppresses `int_ack`, even in the cycle where the count expires.
- R11: For cycles with `ext_master` = 1 and control bit 5 (mask-applies-to-masters) at 0, attribute bits 2 to 5 are ignored, while bit 1 still applies.
- R12: `cyc_start` is sampled at a clock edge. The select goes low after that edge and returns high after the edge that samples an acknowledge. At most one select is low at any time, and a `cyc_start` during an active select is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Channel and field select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| cyc_start | input | 1 | Bus-cycle start strobe |
| bus_addr | input | 32 | Bus address |
| acc_type | input | 3 | Access type code |
| ext_master | input | 1 | Cycle comes from an external master or DMA |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | 8 | Active-low chip selects |
| int_ack | output | 1 | Internal transfer acknowledge |

## Verification
The assertions check on every cycle that at most one select is low, that `ext_ack` always masks `int_ack`, that a channel with auto-acknowledge off never acknowledges, that the wait count stays within its programmed limit, and that a cycle closes on the edge after any acknowledge. Only the bench scenarios can show which channel wins for a given address, access type and master. These include the boot-time global decode, the valid-bit gating, the priority order and the master exception to the access-type mask. The bench scenarios also confirm the exact cycle in which the acknowledge rises, for several wait counts and several external-acknowledge timings.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CMP_W  = 16;
  localparam int WS_W   = 4;
  localparam int TYPE_N = 5;
  localparam int CTL_AA = 8;
  localparam int CTL_AM = 5;

  typedef struct packed {
    logic [CMP_W-1:0]  base;
    logic [CMP_W-1:0]  mask;
    logic [WS_W-1:0]   ws;
    logic [8:0]        ctl_lo;
    logic              valid;
    logic [TYPE_N-1:0] amask;
  } chan_t;

  function automatic logic range_hit(logic [CMP_W-1:0] a, logic [CMP_W-1:0] b,
                                     logic [CMP_W-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  function automatic logic type_blocked(logic [TYPE_N-1:0] am, logic [2:0] typ,
                                        logic xm, logic am_en);
    if (int'(typ) >= TYPE_N) return 1'b0;
    if (xm && !am_en && typ != 3'd0) return 1'b0;
    return am[typ];
  endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs import csel_pkg::*; #(
  parameter int NCH   = 8,
  parameter int SEL_W = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [SEL_W+1:0]     addr,
  input  logic [15:0]          wdata,
  output logic [15:0]          rdata,
  output chan_t [NCH-1:0]      chans
);
  logic [SEL_W-1:0] ch_idx;
  logic [1:0]       fld;
  assign ch_idx = addr[SEL_W+1:2];
  assign fld    = addr[1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = wr && (int'(ch_idx) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chans[i].base   <= '0;
        chans[i].mask   <= (i == 0) ? '1 : '0;
        chans[i].ws     <= (i == 0) ? '1 : '0;
        chans[i].ctl_lo <= (i == 0) ? 9'h100 : 9'h000;
        chans[i].valid  <= 1'b0;
        chans[i].amask  <= '0;
      end else if (sel) begin
        case (fld)
          2'd0: chans[i].base <= wdata;
          2'd1: chans[i].mask <= wdata;
          2'd2: begin
            chans[i].ws     <= wdata[13:10];
            chans[i].ctl_lo <= wdata[8:0];
          end
          default: begin
            chans[i].valid <= wdata[0];
            chans[i].amask <= wdata[TYPE_N:1];
          end
        endcase
      end
    end
  end

  always_comb begin
    chan_t c;
    c = chans[ch_idx];
    case (fld)
      2'd0:    rdata = c.base;
      2'd1:    rdata = c.mask;
      2'd2:    rdata = {2'b00, c.ws, 1'b0, c.ctl_lo};
      default: rdata = {{(15-TYPE_N){1'b0}}, c.amask, c.valid};
    endcase
  end
endmodule

// File: rtl/csel_decode.sv
module csel_decode import csel_pkg::*; #(
  parameter int NCH   = 8,
  parameter int SEL_W = $clog2(NCH)
) (
  input  chan_t [NCH-1:0]   chans,
  input  logic [CMP_W-1:0]  addr_hi,
  input  logic [2:0]        typ,
  input  logic              xm,
  output logic              hit,
  output logic [SEL_W-1:0]  win,
  output logic [WS_W-1:0]   win_ws,
  output logic              win_aa
);
  logic [NCH-1:0] elig;

  for (genvar i = 0; i < NCH; i++) begin : g_elig
    logic decoded;
    assign decoded = chans[i].valid
                     && range_hit(addr_hi, chans[i].base, chans[i].mask)
                     && !type_blocked(chans[i].amask, typ, xm, chans[i].ctl_lo[CTL_AM]);
    if (i == 0) begin : g_boot
      assign elig[i] = !chans[i].valid || decoded;
    end else begin : g_norm
      assign elig[i] = decoded;
    end
  end

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) win = SEL_W'(i);
  end

  assign hit    = |elig;
  assign win_ws = chans[win].ws;
  assign win_aa = chans[win].ctl_lo[CTL_AA];
endmodule

// File: rtl/csel_wait.sv
module csel_wait import csel_pkg::*; #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  input  logic [SEL_W-1:0] idx,
  input  logic [WS_W-1:0]  ws,
  input  logic             aa,
  input  logic             ext_ack,
  output logic             active,
  output logic [SEL_W-1:0] sel,
  output logic             int_ack
);
  logic [WS_W-1:0] cnt, ws_q;
  logic            aa_q, launch, done;

  assign launch  = !active && start && hit;
  assign int_ack = active && aa_q && !ext_ack && (cnt == ws_q);
  assign done    = active && (int_ack || ext_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sel    <= '0;
      cnt    <= '0;
      ws_q   <= '0;
      aa_q   <= 1'b0;
    end else if (launch) begin
      active <= 1'b1;
      sel    <= idx;
      cnt    <= '0;
      ws_q   <= ws;
      aa_q   <= aa;
    end else if (done) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && cnt != ws_q) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r10_ext_masks_int: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> !int_ack);
  a_r9_no_auto_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !aa_q) |-> !int_ack);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= ws_q));
  a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (int_ack || ext_ack)) |=> !active);
  a_r12_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && start && hit) |=> (active && cnt == '0));
endmodule

// File: rtl/csel_unit.sv
module csel_unit import csel_pkg::*; #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [$clog2(NCH)+1:0]    reg_addr,
  input  logic [15:0]               reg_wdata,
  output logic [15:0]               reg_rdata,
  input  logic                      cyc_start,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [2:0]                acc_type,
  input  logic                      ext_master,
  input  logic                      ext_ack,
  output logic [NCH-1:0]            cs_n,
  output logic                      int_ack
);
  localparam int SEL_W = $clog2(NCH);

  chan_t [NCH-1:0]   chans;
  logic              dec_hit, active, dec_aa;
  logic [SEL_W-1:0]  dec_win, sel;
  logic [WS_W-1:0]   dec_ws;

  csel_regs #(.NCH(NCH), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .chans(chans));

  csel_decode #(.NCH(NCH), .SEL_W(SEL_W)) u_dec (
    .chans(chans), .addr_hi(bus_addr[ADDR_W-1 -: CMP_W]), .typ(acc_type),
    .xm(ext_master), .hit(dec_hit), .win(dec_win), .win_ws(dec_ws), .win_aa(dec_aa));

  csel_wait #(.SEL_W(SEL_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .hit(dec_hit), .idx(dec_win),
    .ws(dec_ws), .aa(dec_aa), .ext_ack(ext_ack), .active(active), .sel(sel),
    .int_ack(int_ack));

  for (genvar i = 0; i < NCH; i++) begin : g_cs
    assign cs_n[i] = !(active && int'(sel) == i);
  end

  a_r12_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r12_ack_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> (cs_n != '1));
endmodule

// File: tb/sim_csel_unit.sv
module sim_csel_unit;
  logic        clk = 0, rst_n = 0, reg_wr = 0, cyc_start = 0, ext_master = 0, ext_ack = 0;
  logic [4:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [31:0] bus_addr = 0;
  logic [2:0]  acc_type = 0;
  logic [7:0]  cs_n;
  logic        int_ack;
  int checks = 0, failures = 0;
  bit pending = 0, busy = 0, finished = 0;

  typedef struct { logic [7:0] cs; int len; int intk; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  csel_unit u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_start(cyc_start),
    .bus_addr(bus_addr), .acc_type(acc_type), .ext_master(ext_master),
    .ext_ack(ext_ack), .cs_n(cs_n), .int_ack(int_ack));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int ch, int fld, logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = 5'(ch * 4 + fld); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd_chk(string tag, int ch, int fld, logic [15:0] exp);
    reg_addr = 5'(ch * 4 + fld); #1;
    chk(tag, int'(reg_rdata), int'(exp));
  endtask

  // Driver: pushes the expected outcome, then runs one bus cycle.
  task automatic bus_cycle(string tag, logic [31:0] a, logic [2:0] t, logic xm,
                           int hold, int j, int ch, int ws, bit aa);
    exp_t e;
    int jj;
    jj = (j == 0) ? 99 : j;
    e.tag = tag;
    e.cs = (ch < 0) ? 8'hFF : ~(8'h01 << ch);
    if (ch < 0) begin e.len = 0; e.intk = 0; end
    else if (aa) begin
      e.len  = (ws + 1 < jj) ? ws + 1 : jj;
      e.intk = (ws + 1 < jj) ? ws + 1 : 0;
    end else begin e.len = jj; e.intk = 0; end
    q.push_back(e);
    @(posedge clk); #1;
    bus_addr = a; acc_type = t; ext_master = xm; cyc_start = 1; pending = 1;
    @(posedge clk); #1;
    for (int k = 1; k <= 20; k++) begin
      cyc_start = (k < hold);
      ext_ack = (k == j);
      @(posedge clk); #1;
    end
    ext_ack = 0; cyc_start = 0;
    wait (busy == 0);
  endtask

  // Monitor: pops the expected item and compares what the design produces.
  initial begin
    forever begin
      @(negedge clk);
      if (pending) begin
        exp_t it;
        int len, intk, bad;
        pending = 0; busy = 1;
        it = q.pop_front();
        len = 0; intk = 0; bad = 0;
        for (int k = 1; k <= 20; k++) begin
          @(negedge clk);
          if (cs_n != 8'hFF) begin
            len++;
            if (cs_n != it.cs) bad = int'(cs_n);
            if (int_ack) intk = k;
          end else if (int_ack) bad = 16'h1FF;
        end
        chk({it.tag, " select length"}, len, it.len);
        chk({it.tag, " internal ack cycle"}, intk, it.intk);
        chk({it.tag, " wrong select"}, bad, 0);
        busy = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R2 idle selects", int'(cs_n), 'hFF);
    chk("R2 idle int_ack", int'(int_ack), 0);
    rd_chk("R2 ch0 control", 0, 2, 16'h3D00);
    rd_chk("R2 ch0 mask", 0, 1, 16'hFFFF);
    rd_chk("R2 ch0 attribute", 0, 3, 16'h0000);
    rd_chk("R2 ch3 control", 3, 2, 16'h0000);
    // R6 and R8: global boot select, 15 wait states
    bus_cycle("R6 boot global", 32'h1234_5678, 3'd4, 0, 1, 0, 0, 15, 1);
    // R1: reserved bits
    wr_reg(5, 2, 16'hFFFF); rd_chk("R1 control reserved", 5, 2, 16'h3DFF);
    wr_reg(5, 3, 16'hFFFF); rd_chk("R1 attribute width", 5, 3, 16'h003F);
    wr_reg(5, 1, 16'hA5C3); rd_chk("R1 mask readback", 5, 1, 16'hA5C3);
    wr_reg(5, 3, 16'h0000); wr_reg(5, 2, 16'h0000);
    // channel 0 leaves boot mode
    wr_reg(0, 2, 16'h0900); wr_reg(0, 0, 16'h0000); wr_reg(0, 1, 16'h00FF);
    wr_reg(0, 3, 16'h0001);
    bus_cycle("R6 ch0 valid decode", 32'h0012_0000, 3'd2, 0, 1, 0, 0, 2, 1);
    bus_cycle("R6 ch0 no longer global", 32'h1234_0000, 3'd2, 0, 1, 0, -1, 0, 0);
    // R5 valid gating
    wr_reg(1, 0, 16'h4000); wr_reg(1, 1, 16'h000F); wr_reg(1, 2, 16'h0100);
    bus_cycle("R5 invalid ch1", 32'h4003_0000, 3'd4, 0, 1, 0, -1, 0, 0);
    wr_reg(1, 3, 16'h0001);
    bus_cycle("R3 R8 ch1 zero wait", 32'h4003_0000, 3'd4, 0, 1, 0, 1, 0, 1);
    bus_cycle("R3 outside range", 32'h4010_0000, 3'd4, 0, 1, 0, -1, 0, 0);
    // R7 priority with overlapping ch2
    wr_reg(2, 0, 16'h4000); wr_reg(2, 1, 16'h00FF); wr_reg(2, 2, 16'h0D00);
    wr_reg(2, 3, 16'h0001);
    bus_cycle("R7 lowest wins", 32'h4003_0000, 3'd4, 0, 1, 0, 1, 0, 1);
    bus_cycle("R8 ch2 three waits", 32'h4050_0000, 3'd4, 0, 1, 0, 2, 3, 1);
    // R4 access-type mask
    wr_reg(2, 3, 16'h0021);
    bus_cycle("R4 user data blocked", 32'h4050_0000, 3'd4, 0, 1, 0, -1, 0, 0);
    bus_cycle("R4 user code allowed", 32'h4050_0000, 3'd3, 0, 1, 0, 2, 3, 1);
    // R11 external master
    bus_cycle("R11 master ignores mask", 32'h4050_0000, 3'd4, 1, 1, 0, 2, 3, 1);
    wr_reg(2, 3, 16'h0023);
    bus_cycle("R11 cpu space still masked", 32'h4050_0000, 3'd0, 1, 1, 0, -1, 0, 0);
    wr_reg(2, 2, 16'h0D20);
    bus_cycle("R11 mask applies to master", 32'h4050_0000, 3'd4, 1, 1, 0, -1, 0, 0);
    wr_reg(2, 2, 16'h0D00); wr_reg(2, 3, 16'h0001);
    // R10 external acknowledge
    bus_cycle("R10 early external ack", 32'h4050_0000, 3'd1, 0, 1, 2, 2, 3, 1);
    bus_cycle("R10 same-cycle external ack", 32'h4050_0000, 3'd1, 0, 1, 4, 2, 3, 1);
    // R12 restart strobe ignored
    bus_cycle("R12 strobe during select", 32'h4050_0000, 3'd1, 0, 2, 0, 2, 3, 1);
    // R9 auto-ack off
    wr_reg(3, 0, 16'h8000); wr_reg(3, 1, 16'h0000); wr_reg(3, 2, 16'h0400);
    wr_reg(3, 3, 16'h0001);
    bus_cycle("R9 external only", 32'h8000_1234, 3'd2, 0, 1, 5, 3, 1, 0);
    @(negedge clk);
    chk("R12 idle after cycles", int'(cs_n), 'hFF);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule